// File: doc/BRIEF.md
# Two-Wire Debug Link Master

This block is the host end of a two-wire debug link. It drives a debug clock, a bidirectional data line and an active-low target reset. On request it walks the target into debug mode, walks it out again, shifts one byte out to the target, or shifts one byte in from it. A transfer either writes or reads. The data line is driven only while a byte is being sent, and it is released while a byte is received. The data line is brought out as a separate output value, output enable and input, and a pad-level tristate buffer joins them.

A request is a one-cycle `req_valid` with an operation code and, for a send, a data byte. The block raises `busy` for the whole operation. At the end it gives a one-cycle `done`, and after a receive it holds the received byte on `rsp_data`. The debug clock runs from a divided system clock. The divider setting is raised automatically so that the debug clock never exceeds the target's rate limit.

Top module: `dbg_link_master`

## Requirements
- R1: Out of reset, `busy`, `done`, `dbg_clk` and `dbg_data_oe` are 0 and `dbg_rst_n` is 1.
- R2: Operation code 0 (enter) pulls `dbg_rst_n` low for 5 half periods. While it is low, exactly two `dbg_clk` high pulses occur. `dbg_clk` is low when `dbg_rst_n` returns high.
- R3: Operation code 1 (exit) pulls `dbg_rst_n` low for 2 half periods and produces no `dbg_clk` edge.
- R4: Operation code 2 (send) drives the line with `dbg_data_oe` high and `req_data` bit 7 first. Each bit is placed on `dbg_data_o` one half period before its rising clock edge and held while the clock is high. After the eighth rising edge the line is released.
- R5: Operation code 3 (receive) keeps `dbg_data_oe` low. It samples `dbg_data_i` at each of 8 falling `dbg_clk` edges and shifts each bit in most significant first. The byte appears on `rsp_data` with `done`.
- R6: Every high and low phase of `dbg_clk` inside an operation lasts max(HALF_DIV, ceil(SYS_HZ / (2 * MAX_DBG_HZ))) system clocks. The clock idles low.
- R7: For a receive, the first rising `dbg_clk` edge comes exactly TURN_CYC system clocks after the request is accepted, with the line released throughout.
- R8: `busy` rises in the cycle after a request is accepted. Each operation ends with exactly one single-cycle `done`, and `busy` is low in that cycle.
- R9: A `req_valid` pulse while `busy` is high is ignored. The running operation's bit stream and result are unchanged, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken when idle |
| req_op | input | 2 | 0 enter, 1 exit, 2 send, 3 receive |
| req_data | input | 8 | Byte to send |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Last received byte |
| dbg_clk | output | 1 | Debug clock to target |
| dbg_rst_n | output | 1 | Active-low target reset |
| dbg_data_o | output | 1 | Data line value when driven |
| dbg_data_oe | output | 1 | Data line drive enable |
| dbg_data_i | input | 1 | Data line value read back |

## Verification
A wrong phase or half-period count shows at once as a clock phase of the wrong length, or as a wrong number of clock pulses while reset is low. Both are visible within the operation that caused them. A fault in the shift path shows as a wrong bit on the line at a rising edge, or as a wrong `rsp_data` at the `done` of the same receive. A state machine that accepts a request while busy, or that leaves an operation at the wrong point, shows as a missing or extra `done` or a `busy` that is still high. This is caught within a few cycles after the operation ends.

// File: rtl/dbg_link_pkg.sv
// Shared types for the two-wire debug link master.
// Assumes: operation codes are fixed at the request port.
package dbg_link_pkg;

    typedef enum logic [1:0] {
        OP_ENTER = 2'd0,
        OP_EXIT  = 2'd1,
        OP_SEND  = 2'd2,
        OP_RECV  = 2'd3
    } link_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_EXIT,
        ST_SEND,
        ST_TURN,
        ST_RECV
    } link_state_e;

endpackage

// File: rtl/dbg_half_tick.sv
// Half-period tick generator. While en is high, it pulses tick once every
// HALF system clocks, with the first pulse HALF clocks after en rises.
// Assumes: HALF >= 1. The count restarts whenever en is low.
module dbg_half_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);

    generate
        if (HALF > 1) begin : g_spacing
            // R6
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/dbg_shift8.sv
// Serial shift register. It loads in parallel and shifts left, taking a new
// bit into the LSB. The MSB is the outgoing serial bit.
// Assumes: load and shift are never high in the same cycle.
module dbg_shift8 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    // Load or shift the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (load) q <= load_val;
        else if (shift) q <= {q[W-2:0], shift_in};
    end
endmodule

// File: rtl/dbg_link_seq.sv
// Sequencer for the debug link. It takes requests when idle and steps
// through the enter, exit, send, turnaround and receive phases on half-period
// ticks. It drives the link clock, reset and output enable from registers.
// Assumes: tick comes from a generator enabled by tick_en.
module dbg_link_seq
    import dbg_link_pkg::*;
#(
    parameter int W        = 8,
    parameter int TURN_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [1:0]   req_op,
    input  logic         tick,
    input  logic [W-1:0] sh_q,
    output logic         tick_en,
    output logic         sh_load,
    output logic         sh_shift,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] rsp_data,
    output logic         lk_clk,
    output logic         lk_rst_n,
    output logic         lk_oe
);
    localparam int PH_W = $clog2(2 * W);
    localparam int TC_W = $clog2(TURN_CYC + 1);
    localparam logic [PH_W-1:0] XFER_LAST  = PH_W'(2 * W - 1);
    localparam logic [PH_W-1:0] ENTER_LAST = PH_W'(4);
    localparam logic [PH_W-1:0] EXIT_LAST  = PH_W'(1);
    localparam logic [TC_W-1:0] TURN_LAST  = TC_W'(TURN_CYC - 1);

    link_state_e     state;
    logic [PH_W-1:0] ph;
    logic [TC_W-1:0] tc;

    // Step the phase machine and its registered link outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ph       <= '0;
            tc       <= '0;
            lk_clk   <= 1'b0;
            lk_rst_n <= 1'b1;
            lk_oe    <= 1'b0;
            done     <= 1'b0;
            rsp_data <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ph <= '0;
                        tc <= '0;
                        case (link_op_e'(req_op))
                            OP_ENTER: begin lk_rst_n <= 1'b0; state <= ST_ENTER; end
                            OP_EXIT:  begin lk_rst_n <= 1'b0; state <= ST_EXIT;  end
                            OP_SEND:  begin lk_oe    <= 1'b1; state <= ST_SEND;  end
                            default:  state <= ST_TURN;
                        endcase
                    end
                end
                ST_ENTER: begin
                    if (tick) begin
                        if (ph == ENTER_LAST) begin
                            lk_rst_n <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            lk_clk <= ~lk_clk;
                            ph     <= ph + 1'b1;
                        end
                    end
                end
                ST_EXIT: begin
                    if (tick) begin
                        if (ph == EXIT_LAST) begin
                            lk_rst_n <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (ph == XFER_LAST) begin
                            lk_clk <= 1'b0;
                            lk_oe  <= 1'b0;
                            done   <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            lk_clk <= ~ph[0];
                            ph     <= ph + 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (tc == TURN_LAST) begin
                        lk_clk <= 1'b1;
                        ph     <= '0;
                        state  <= ST_RECV;
                    end else begin
                        tc <= tc + 1'b1;
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (ph == XFER_LAST) begin
                            rsp_data <= sh_q;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            lk_clk <= ph[0];
                            ph     <= ph + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode the tick enable and shifter controls from the current phase.
    always_comb begin
        tick_en  = (state == ST_ENTER) || (state == ST_EXIT) ||
                   (state == ST_SEND)  || (state == ST_RECV);
        sh_load  = (state == ST_IDLE) && req_valid && (req_op == OP_SEND);
        sh_shift = tick && (((state == ST_SEND) && ph[0] && (ph != XFER_LAST)) ||
                            ((state == ST_RECV) && !ph[0]));
        busy     = (state != ST_IDLE);
    end

    // R2
    rst_low_only_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_rst_n |-> ((state == ST_ENTER) || (state == ST_EXIT)));
    // R2
    rst_release_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lk_rst_n) |-> !lk_clk);
    // R6
    clk_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_clk != $past(lk_clk)) |-> ($past(tick) || $past(state == ST_TURN)));
    // R5
    released_in_recv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TURN) || (state == ST_RECV)) |-> !lk_oe);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/dbg_link_master.sv
// Top level of the two-wire debug link master. It joins the half-period tick
// generator, the byte shifter and the sequencer. The half period is raised
// so that the debug clock stays at or below MAX_DBG_HZ.
// Assumes: SYS_HZ is the clk frequency and the data line pad is outside.
module dbg_link_master #(
    parameter int SYS_HZ     = 50_000_000,
    parameter int MAX_DBG_HZ = 30_000_000,
    parameter int HALF_DIV   = 2,
    parameter int TURN_CYC   = 3,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_data,
    output logic              dbg_clk,
    output logic              dbg_rst_n,
    output logic              dbg_data_o,
    output logic              dbg_data_oe,
    input  logic              dbg_data_i
);
    localparam int MIN_HALF = (SYS_HZ + 2 * MAX_DBG_HZ - 1) / (2 * MAX_DBG_HZ);
    localparam int EFF_HALF = (HALF_DIV > MIN_HALF) ? HALF_DIV : MIN_HALF;

    logic              tick_en;
    logic              tick;
    logic              sh_load;
    logic              sh_shift;
    logic [DATA_W-1:0] sh_q;

    dbg_half_tick #(.HALF(EFF_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    dbg_shift8 #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (req_data),
        .shift    (sh_shift),
        .shift_in (dbg_data_i),
        .q        (sh_q)
    );

    dbg_link_seq #(.W(DATA_W), .TURN_CYC(TURN_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .tick      (tick),
        .sh_q      (sh_q),
        .tick_en   (tick_en),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .busy      (busy),
        .done      (done),
        .rsp_data  (rsp_data),
        .lk_clk    (dbg_clk),
        .lk_rst_n  (dbg_rst_n),
        .lk_oe     (dbg_data_oe)
    );

    assign dbg_data_o = sh_q[DATA_W-1];

    // R4
    send_bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_data_oe && dbg_clk && $past(dbg_clk) && $past(dbg_data_oe)) |-> $stable(dbg_data_o));
endmodule

// File: tb/tb_dbg_link_master.sv
// Bench for dbg_link_master. It runs directed corner cases and seeded random
// operations. A target model answers receives, and edge monitors check the link.
module tb_dbg_link_master;
    localparam int H = 2;   // max(2, ceil(50 MHz / 60 MHz))
    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [7:0] req_data = 8'h00;
    logic       busy, done, dbg_clk, dbg_rst_n, dbg_data_o, dbg_data_oe;
    logic [7:0] rsp_data;
    logic       dbg_data_i = 1'b0;

    dbg_link_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_data(req_data), .busy(busy), .done(done), .rsp_data(rsp_data),
        .dbg_clk(dbg_clk), .dbg_rst_n(dbg_rst_n), .dbg_data_o(dbg_data_o),
        .dbg_data_oe(dbg_data_oe), .dbg_data_i(dbg_data_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state, cleared per operation
    logic       prev_clk = 1'b0;
    int         rise_rstlow, rise_any, rst_low_cyc, hi_cnt, lo_cnt, width_err;
    int         sent_n, stab_err, oe_in_recv, turn_cnt, done_cnt;
    logic       seen_fall, seen_rise, last_bit;
    logic [7:0] sent, tgt;
    int         ridx;
    logic [1:0] cur_op;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rise_rstlow = 0; rise_any = 0; rst_low_cyc = 0; hi_cnt = 0; lo_cnt = 0;
        width_err = 0; sent_n = 0; stab_err = 0; oe_in_recv = 0; turn_cnt = 0;
        done_cnt = 0; seen_fall = 1'b0; seen_rise = 1'b0; sent = 8'h00; ridx = 0;
    endtask

    // Edge monitor and target model, sampled on the falling system clock.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dbg_rst_n) rst_low_cyc++;
            if (done) done_cnt++;
            if (cur_op == 2'd3 && busy && dbg_data_oe) oe_in_recv++;
            if (cur_op == 2'd3 && busy && !dbg_clk && !seen_rise) turn_cnt++;
            if (dbg_clk && !prev_clk) begin
                rise_any++;
                if (!dbg_rst_n) rise_rstlow++;
                if (seen_fall && lo_cnt != H) width_err++;
                seen_rise = 1'b1;
                hi_cnt = 0;
                if (dbg_data_oe) begin
                    sent = {sent[6:0], dbg_data_o};
                    last_bit = dbg_data_o;
                    sent_n++;
                end else if (ridx < 8) begin
                    dbg_data_i <= tgt[7-ridx];
                    ridx++;
                end
            end else if (!dbg_clk && prev_clk) begin
                if (hi_cnt != H) width_err++;
                seen_fall = 1'b1;
                lo_cnt = 0;
            end
            if (dbg_clk && prev_clk && dbg_data_oe && dbg_data_o != last_bit) stab_err++;
            if (dbg_clk) hi_cnt++; else lo_cnt++;
            prev_clk = dbg_clk;
        end
    end

    // Issue one operation, optionally with a stray request while busy.
    task automatic run_op(input logic [1:0] op, input logic [7:0] d, input logic [7:0] t, input bit stray);
        int wait_n;
        @(negedge clk); #2;
        clear_mon();
        cur_op = op; tgt = t;
        req_valid = 1'b1; req_op = op; req_data = d;
        @(negedge clk); #2;
        req_valid = 1'b0;
        chk(busy === 1'b1, "R8 busy after accept", busy, 1);
        if (stray) begin
            repeat (1 + ($urandom % 3)) @(negedge clk);
            #2;
            req_valid = 1'b1; req_op = op ^ 2'd1; req_data = ~d;
            @(negedge clk); #2;
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 300) begin @(negedge clk); #2; wait_n++; end
        chk(done === 1'b1, "R8 done seen", done, 1);
        chk(busy === 1'b0, "R8 busy low at done", busy, 0);
        if (op == 2'd3) chk(rsp_data === t, "R5 received byte", rsp_data, t);
        repeat (4) @(negedge clk);
        #2;
        chk(done_cnt == 1, stray ? "R9 single done with stray request" : "R8 single done", done_cnt, 1);
        chk(busy === 1'b0 && dbg_clk === 1'b0, "R9 idle after op", {busy, dbg_clk}, 0);
        chk(width_err == 0, "R6 half-period width", width_err, 0);
        case (op)
            2'd0: begin
                chk(rise_rstlow == 2 && rise_any == 2, "R2 two pulses in reset", rise_rstlow, 2);
                chk(rst_low_cyc == 5 * H, "R2 reset low time", rst_low_cyc, 5 * H);
            end
            2'd1: begin
                chk(rise_any == 0, "R3 no clock on exit", rise_any, 0);
                chk(rst_low_cyc == 2 * H, "R3 reset low time", rst_low_cyc, 2 * H);
            end
            2'd2: begin
                chk(sent_n == 8 && sent == d, stray ? "R9 send bits with stray" : "R4 send bits", sent, d);
                chk(stab_err == 0, "R4 bit held while high", stab_err, 0);
                chk(dbg_data_oe === 1'b0, "R4 released after send", dbg_data_oe, 0);
            end
            default: begin
                chk(oe_in_recv == 0, "R5 line released", oe_in_recv, 0);
                chk(turn_cnt == T, "R7 turnaround", turn_cnt, T);
                chk(rise_any == 8, "R5 eight clocks", rise_any, 8);
            end
        endcase
    endtask

    bit finished = 1'b0;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Main sequence: reset, directed corners, then random operations.
    initial begin
        void'($urandom(32'h1D2C3B4A));
        cur_op = 2'd0; tgt = 8'h00; last_bit = 1'b0;
        clear_mon();
        repeat (3) @(negedge clk);
        #2;
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", {busy, done}, 0);
        chk(dbg_clk === 1'b0 && dbg_data_oe === 1'b0 && dbg_rst_n === 1'b1, "R1 reset link pins",
            {dbg_clk, dbg_data_oe, dbg_rst_n}, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #2;
        chk(busy === 1'b0 && dbg_rst_n === 1'b1, "R1 idle after reset", {busy, dbg_rst_n}, 1);

        run_op(2'd0, 8'h00, 8'h00, 1'b0);
        run_op(2'd2, 8'hA5, 8'h00, 1'b0);
        run_op(2'd2, 8'h00, 8'h00, 1'b0);
        run_op(2'd2, 8'hFF, 8'h00, 1'b0);
        run_op(2'd3, 8'h00, 8'h80, 1'b0);
        run_op(2'd3, 8'h00, 8'h01, 1'b0);
        run_op(2'd2, 8'h3C, 8'h00, 1'b1);
        run_op(2'd3, 8'h00, 8'hC3, 1'b1);
        run_op(2'd1, 8'h00, 8'h00, 1'b0);
        run_op(2'd0, 8'h00, 8'h00, 1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [1:0] op;
            op = 2'(2 + ($urandom % 2));
            if (($urandom % 8) == 0) op = 2'($urandom % 2);
            run_op(op, 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule